// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block stores the programmer-visible registers of an 8-bit processor whose datapath also handles 16-bit pairs. Four pairs are banked, each with a main and an alternate copy: the accumulator/flags pair (A and F), and the BC, DE and HL pairs. Three 16-bit registers sit outside both banks: IX, IY and the stack pointer SP. Two combinational read ports and one synchronous write port serve the datapath, and each can work on a single byte or a whole pair.

Two exchange strobes change which copy is visible. One acts on the accumulator/flags pair alone. The other acts on BC, DE and HL together. Each strobe drives a two-state machine with the states BANK_MAIN and BANK_ALT. When the strobe is high, the machine takes the SWAP_TO_ALT or SWAP_TO_MAIN transition at the next clock edge. When the strobe is low, it takes the HOLD transition. Reset forces the machine to BANK_MAIN. No data moves between the copies, so the same exchange done twice gives back the original view. The flags byte has no address on the general ports. It is reached only as the low half of the whole accumulator/flags pair, through the stack push and pop path, or through the ALU flag-update port.

Top module: `cpu_regbank`

## Requirements
- R1: A synchronous reset sets every register in both banks, plus IX, IY and SP, to zero, and puts both exchange state machines in BANK_MAIN.
- R2: The 8-bit register codes are B=0, C=1, D=2, E=3, H=4, L=5 and A=6. A byte read returns the byte in bits 7:0 with zeros above it. Code 7 reads as zero, and a byte write with code 7 changes nothing.
- R3: The 16-bit register codes are BC=0, DE=1, HL=2, IX=3, IY=4 and SP=5. Codes 6 and 7 read as zero, and a pair write with either code changes nothing. A pair's high byte is the first-named register.
- R4: An accumulator exchange strobe switches which copy of A and F is visible, in one clock. BC, DE and HL are left as they are. Two such exchanges restore the original view.
- R5: A group exchange strobe switches the visible copies of BC, DE and HL together, in one clock. A and F are left as they are.
- R6: IX, IY and SP keep their values through any exchange.
- R7: A write in the same cycle as an exchange of its bank lands in the copy that was visible before the exchange.
- R8: The push/pop path reads {A,F} of the visible bank and writes all 16 bits of it, including the four flag bits that have no defined meaning (bits 5, 4, 3 and 1).
- R9: The flag-update port changes only the defined flag bits: sign at bit 7, zero at bit 6, parity/overflow at bit 2 and carry at bit 0. The other four bits of F keep their values.
- R10: If a pop write and a byte write of A, or a flag update, happen in the same cycle, the pop write wins.
- R11: The two read ports work independently and combinationally. Each one reflects the registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 3 | Read port A register code |
| rd_a_wide | input | 1 | Read port A: 1 = pair code, 0 = byte code |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 3 | Read port B register code |
| rd_b_wide | input | 1 | Read port B: 1 = pair code, 0 = byte code |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | Write: 1 = pair code, 0 = byte code |
| wr_sel | input | 3 | Write register code |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |
| xchg_af | input | 1 | Accumulator/flags exchange strobe |
| xchg_grp | input | 1 | BC/DE/HL group exchange strobe |
| flag_we | input | 1 | ALU flag-update strobe |
| flag_in | input | 8 | New flag values; only the defined flag bits are used |
| af_we | input | 1 | Pop write of the whole A/F pair |
| af_wdata | input | 16 | Pop data {A,F} |
| af_rdata | output | 16 | Push data {A,F} of the visible bank |

## Verification
The bench builds the block with the default byte width of 8, so each pair is 16 bits wide and the flag mask covers the real sign, zero, parity/overflow and carry positions. This width lets the bench write literal 16-bit vectors that check the four spare flag bits by value. It can also set up the collisions that matter: a write in the same cycle as an exchange, and a pop write in the same cycle as a byte write or a flag update. A reference model of both banks and both exchange states then checks a long random mix of writes, exchanges, pops and flag updates.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_ALT  = 1'b1
    } bank_t;

    // byte register codes
    localparam logic [2:0] R8_B = 3'd0;
    localparam logic [2:0] R8_C = 3'd1;
    localparam logic [2:0] R8_D = 3'd2;
    localparam logic [2:0] R8_E = 3'd3;
    localparam logic [2:0] R8_H = 3'd4;
    localparam logic [2:0] R8_L = 3'd5;
    localparam logic [2:0] R8_A = 3'd6;

    // pair register codes
    localparam logic [2:0] R16_BC = 3'd0;
    localparam logic [2:0] R16_DE = 3'd1;
    localparam logic [2:0] R16_HL = 3'd2;
    localparam logic [2:0] R16_IX = 3'd3;
    localparam logic [2:0] R16_IY = 3'd4;
    localparam logic [2:0] R16_SP = 3'd5;

    // defined flags: sign 7, zero 6, parity/overflow 2, carry 0
    localparam logic [7:0] FLAG_DEF_MASK = 8'hC5;

    // banked pair slots
    localparam int PAIR_AF = 0;
    localparam int NUM_PAIRS = 4;

endpackage

// File: rtl/xchg_fsm.sv
module xchg_fsm
    import regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  xchg,
    output bank_t bank
);

    bank_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BANK_MAIN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_MAIN: if (xchg) state_d = BANK_ALT;
            BANK_ALT:  if (xchg) state_d = BANK_MAIN;
            default:   state_d = BANK_MAIN;
        endcase
    end

    assign bank = state_q;

    // R4
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        xchg |=> (bank != $past(bank)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xchg |=> $stable(bank));

endmodule

// File: rtl/banked_pair.sv
module banked_pair
    import regfile_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_t             bank_sel,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store_q [2];
    logic              idx;

    assign idx = (bank_sel == BANK_ALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q[0] <= '0;
            store_q[1] <= '0;
        end else begin
            if (we_hi) store_q[idx][WORD_W-1:BYTE_W] <= wdata[WORD_W-1:BYTE_W];
            if (we_lo) store_q[idx][BYTE_W-1:0]      <= wdata[BYTE_W-1:0];
        end
    end

    assign rdata = store_q[idx];

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import regfile_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        rd_a_sel,
    input  logic              rd_a_wide,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [2:0]        rd_b_sel,
    input  logic              rd_b_wide,
    output logic [WORD_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              xchg_af,
    input  logic              xchg_grp,
    input  logic              flag_we,
    input  logic [BYTE_W-1:0] flag_in,
    input  logic              af_we,
    input  logic [WORD_W-1:0] af_wdata,
    output logic [WORD_W-1:0] af_rdata
);

    localparam logic [BYTE_W-1:0] FMASK = BYTE_W'(FLAG_DEF_MASK);

    bank_t af_bank, grp_bank;

    xchg_fsm u_af_fsm  (.clk(clk), .rst(rst), .xchg(xchg_af),  .bank(af_bank));
    xchg_fsm u_grp_fsm (.clk(clk), .rst(rst), .xchg(xchg_grp), .bank(grp_bank));

    logic we8, we16;
    assign we8  = wr_en && !wr_wide;
    assign we16 = wr_en &&  wr_wide;

    logic [WORD_W-1:0] pair_rd [NUM_PAIRS];
    logic              pair_we_hi [NUM_PAIRS];
    logic              pair_we_lo [NUM_PAIRS];
    logic [WORD_W-1:0] pair_wd [NUM_PAIRS];
    logic [BYTE_W-1:0] f_upd;

    assign f_upd = (pair_rd[PAIR_AF][BYTE_W-1:0] & ~FMASK) | (flag_in & FMASK);

    // accumulator/flags pair: pop path wins over byte write and flag port
    assign pair_we_hi[PAIR_AF] = af_we || (we8 && wr_sel == R8_A);
    assign pair_we_lo[PAIR_AF] = af_we || flag_we;
    assign pair_wd[PAIR_AF]    = af_we ? af_wdata : {wr_data[BYTE_W-1:0], f_upd};

    genvar p;
    generate
        for (p = 1; p < NUM_PAIRS; p++) begin : g_grp_dec
            localparam logic [2:0] C8_HI = 3'(2 * (p - 1));
            localparam logic [2:0] C8_LO = 3'(2 * (p - 1) + 1);
            localparam logic [2:0] C16   = 3'(p - 1);
            assign pair_we_hi[p] = (we8 && wr_sel == C8_HI) || (we16 && wr_sel == C16);
            assign pair_we_lo[p] = (we8 && wr_sel == C8_LO) || (we16 && wr_sel == C16);
            assign pair_wd[p]    = we16 ? wr_data : {2{wr_data[BYTE_W-1:0]}};
        end
        for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
            banked_pair #(.BYTE_W(BYTE_W)) u_pair (
                .clk     (clk),
                .rst     (rst),
                .bank_sel((p == PAIR_AF) ? af_bank : grp_bank),
                .we_hi   (pair_we_hi[p]),
                .we_lo   (pair_we_lo[p]),
                .wdata   (pair_wd[p]),
                .rdata   (pair_rd[p])
            );
        end
    endgenerate

    // unbanked registers
    logic [WORD_W-1:0] ix_q, iy_q, sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ix_q <= '0;
            iy_q <= '0;
            sp_q <= '0;
        end else if (we16) begin
            if (wr_sel == R16_IX) ix_q <= wr_data;
            if (wr_sel == R16_IY) iy_q <= wr_data;
            if (wr_sel == R16_SP) sp_q <= wr_data;
        end
    end

    // two independent combinational read ports
    logic [2:0]        rp_sel  [2];
    logic              rp_wide [2];
    logic [WORD_W-1:0] rp_data [2];

    assign rp_sel[0]  = rd_a_sel;
    assign rp_wide[0] = rd_a_wide;
    assign rp_sel[1]  = rd_b_sel;
    assign rp_wide[1] = rd_b_wide;
    assign rd_a_data  = rp_data[0];
    assign rd_b_data  = rp_data[1];

    genvar r;
    generate
        for (r = 0; r < 2; r++) begin : g_rport
            logic [BYTE_W-1:0] byte_v;
            always_comb begin
                byte_v = '0;
                case (rp_sel[r])
                    R8_B: byte_v = pair_rd[1][WORD_W-1:BYTE_W];
                    R8_C: byte_v = pair_rd[1][BYTE_W-1:0];
                    R8_D: byte_v = pair_rd[2][WORD_W-1:BYTE_W];
                    R8_E: byte_v = pair_rd[2][BYTE_W-1:0];
                    R8_H: byte_v = pair_rd[3][WORD_W-1:BYTE_W];
                    R8_L: byte_v = pair_rd[3][BYTE_W-1:0];
                    R8_A: byte_v = pair_rd[PAIR_AF][WORD_W-1:BYTE_W];
                    default: byte_v = '0;
                endcase
                if (rp_wide[r]) begin
                    case (rp_sel[r])
                        R16_BC: rp_data[r] = pair_rd[1];
                        R16_DE: rp_data[r] = pair_rd[2];
                        R16_HL: rp_data[r] = pair_rd[3];
                        R16_IX: rp_data[r] = ix_q;
                        R16_IY: rp_data[r] = iy_q;
                        R16_SP: rp_data[r] = sp_q;
                        default: rp_data[r] = '0;
                    endcase
                end else begin
                    rp_data[r] = {{BYTE_W{1'b0}}, byte_v};
                end
            end
        end
    endgenerate

    assign af_rdata = pair_rd[PAIR_AF];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (af_rdata == '0 && ix_q == '0 && iy_q == '0 && sp_q == '0));

    // R8
    af_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (af_we && !xchg_af) |=> (af_rdata == $past(af_wdata)));

    // R9
    user_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !af_we && !xchg_af) |=>
            ((af_rdata[BYTE_W-1:0] & ~FMASK) == $past(af_rdata[BYTE_W-1:0] & ~FMASK)));

    // R5
    grp_keeps_af_chk: assert property (@(posedge clk) disable iff (rst)
        (xchg_grp && !xchg_af && !af_we && !flag_we && !we8) |=> $stable(af_rdata));

    // R6
    ix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(we16 && wr_sel == R16_IX) |=> $stable(ix_q));

    // R6
    sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(we16 && wr_sel == R16_SP) |=> $stable(sp_q));

endmodule

// File: tb/tb_cpu_regbank.sv
`timescale 1ns/1ps
module tb_cpu_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic        rd_a_wide = 1'b0, rd_b_wide = 1'b0;
    logic [15:0] rd_a_data, rd_b_data, af_rdata;
    logic        wr_en = 0, wr_wide = 0, xchg_af = 0, xchg_grp = 0, flag_we = 0, af_we = 0;
    logic [15:0] wr_data = '0, af_wdata = '0;
    logic [7:0]  flag_in = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cpu_regbank dut (
        .clk(clk), .rst(rst),
        .rd_a_sel(rd_a_sel), .rd_a_wide(rd_a_wide), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_wide(rd_b_wide), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .xchg_af(xchg_af), .xchg_grp(xchg_grp),
        .flag_we(flag_we), .flag_in(flag_in),
        .af_we(af_we), .af_wdata(af_wdata), .af_rdata(af_rdata)
    );

    localparam logic [2:0] OP_W8 = 0, OP_W16 = 1, OP_XAF = 2, OP_XGRP = 3, OP_POP = 4, OP_FLAG = 5;
    localparam logic [1:0] CK_8 = 0, CK_16 = 1, CK_AF = 2;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  sel;
        logic [15:0] data;
        logic [1:0]  ck;
        logic [2:0]  csel;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{OP_W16,  3'd2, 16'h1234, CK_16, 3'd2, 16'h1234},  // R3 HL
        '{OP_W8,   3'd6, 16'h005A, CK_AF, 3'd0, 16'h5A00},  // R2 A
        '{OP_POP,  3'd0, 16'hABCD, CK_AF, 3'd0, 16'hABCD},  // R8
        '{OP_XAF,  3'd0, 16'h0000, CK_AF, 3'd0, 16'h0000},  // R4 to alt
        '{OP_POP,  3'd0, 16'h1122, CK_AF, 3'd0, 16'h1122},  // R8 alt
        '{OP_XGRP, 3'd0, 16'h0000, CK_16, 3'd2, 16'h0000},  // R5 alt HL
        '{OP_W16,  3'd2, 16'hBEEF, CK_16, 3'd2, 16'hBEEF},  // R3
        '{OP_XGRP, 3'd0, 16'h0000, CK_16, 3'd2, 16'h1234},  // R5 back
        '{OP_XAF,  3'd0, 16'h0000, CK_AF, 3'd0, 16'hABCD},  // R4 back
        '{OP_FLAG, 3'd0, 16'h0000, CK_AF, 3'd0, 16'hAB08},  // R9 user bit 3 kept
        '{OP_FLAG, 3'd0, 16'h00FF, CK_AF, 3'd0, 16'hABCD},  // R9 only defined bits set
        '{OP_W16,  3'd3, 16'hCAFE, CK_16, 3'd3, 16'hCAFE},  // R3 IX
        '{OP_XGRP, 3'd0, 16'h0000, CK_16, 3'd3, 16'hCAFE},  // R6 IX kept
        '{OP_W8,   3'd4, 16'h0077, CK_16, 3'd2, 16'h77EF},  // R2 H in alt HL
        '{OP_XAF,  3'd0, 16'h0000, CK_8,  3'd6, 16'h0011},  // R4 alt A
        '{OP_W16,  3'd5, 16'hFFFE, CK_16, 3'd5, 16'hFFFE},  // R3 SP
        '{OP_W8,   3'd7, 16'h0099, CK_AF, 3'd0, 16'h1122},  // R2 reserved ignored
        '{OP_W16,  3'd7, 16'h5555, CK_16, 3'd7, 16'h0000},  // R3 reserved
        '{OP_XAF,  3'd0, 16'h0000, CK_AF, 3'd0, 16'hABCD}   // R4 twice restores
    };

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            OP_W8:   return "R2";
            OP_W16:  return "R3";
            OP_XAF:  return "R4";
            OP_XGRP: return "R5";
            OP_POP:  return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic ww, input logic [2:0] ws, input logic [15:0] wd,
                       input logic xa, input logic xg, input logic fwe, input logic [7:0] fin,
                       input logic awe, input logic [15:0] awd);
        @(negedge clk);
        wr_en = we; wr_wide = ww; wr_sel = ws; wr_data = wd;
        xchg_af = xa; xchg_grp = xg; flag_we = fwe; flag_in = fin;
        af_we = awe; af_wdata = awd;
        @(posedge clk);
        #1;
        wr_en = 0; xchg_af = 0; xchg_grp = 0; flag_we = 0; af_we = 0;
    endtask

    task automatic read_a(input logic [2:0] s, input logic w, output logic [15:0] v);
        rd_a_sel = s; rd_a_wide = w; #1; v = rd_a_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
    endtask

    // reference model
    logic [15:0] m_af [2], m_bc [2], m_de [2], m_hl [2];
    logic [15:0] m_ix, m_iy, m_sp;
    logic        s_af, s_g;

    function automatic logic [15:0] m_rd(input logic [2:0] s, input logic w);
        logic [15:0] p;
        if (w) begin
            case (s)
                3'd0: return m_bc[s_g];
                3'd1: return m_de[s_g];
                3'd2: return m_hl[s_g];
                3'd3: return m_ix;
                3'd4: return m_iy;
                3'd5: return m_sp;
                default: return 16'h0;
            endcase
        end
        case (s)
            3'd0, 3'd1: p = m_bc[s_g];
            3'd2, 3'd3: p = m_de[s_g];
            3'd4, 3'd5: p = m_hl[s_g];
            3'd6:       p = {m_af[s_af][15:8], 8'h00};
            default:    return 16'h0;
        endcase
        return s[0] ? {8'h00, p[7:0]} : {8'h00, p[15:8]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        do_reset();

        // R1 reset state
        for (int s = 0; s < 8; s++) begin
            read_a(3'(s), 1'b1, v);
            check("R1", v, 16'h0);
        end
        check("R1", af_rdata, 16'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            t = VECS[i];
            case (t.op)
                OP_W8:   cyc(1, 0, t.sel, t.data, 0, 0, 0, 8'h0, 0, 16'h0);
                OP_W16:  cyc(1, 1, t.sel, t.data, 0, 0, 0, 8'h0, 0, 16'h0);
                OP_XAF:  cyc(0, 0, 3'd0, 16'h0, 1, 0, 0, 8'h0, 0, 16'h0);
                OP_XGRP: cyc(0, 0, 3'd0, 16'h0, 0, 1, 0, 8'h0, 0, 16'h0);
                OP_POP:  cyc(0, 0, 3'd0, 16'h0, 0, 0, 0, 8'h0, 1, t.data);
                default: cyc(0, 0, 3'd0, 16'h0, 0, 0, 1, t.data[7:0], 0, 16'h0);
            endcase
            if (t.ck == CK_AF) v = af_rdata;
            else read_a(t.csel, t.ck == CK_16, v);
            check(op_tag(t.op), v, t.exp);
        end

        // R7 byte write of A together with an AF exchange (AF main = ABCD, alt = 1122)
        cyc(1, 0, 3'd6, 16'h003C, 1, 0, 0, 8'h0, 0, 16'h0);
        check("R7", af_rdata, 16'h1122);
        cyc(0, 0, 3'd0, 16'h0, 1, 0, 0, 8'h0, 0, 16'h0);
        check("R7", af_rdata, 16'h3CCD);
        // R7 pair write with a group exchange (group is on alt)
        cyc(1, 1, 3'd1, 16'h4242, 0, 1, 0, 8'h0, 0, 16'h0);
        read_a(3'd1, 1'b1, v);
        check("R7", v, 16'h0000);
        cyc(0, 0, 3'd0, 16'h0, 0, 1, 0, 8'h0, 0, 16'h0);
        read_a(3'd1, 1'b1, v);
        check("R7", v, 16'h4242);

        // R10 pop beats byte write of A and flag update
        @(negedge clk);
        wr_en = 1; wr_wide = 0; wr_sel = 3'd6; wr_data = 16'h00FF;
        flag_we = 1; flag_in = 8'hFF; af_we = 1; af_wdata = 16'h6789;
        @(posedge clk); #1;
        wr_en = 0; flag_we = 0; af_we = 0;
        check("R10", af_rdata, 16'h6789);

        // R11 both ports at once
        cyc(1, 0, 3'd0, 16'h005E, 0, 0, 0, 8'h0, 0, 16'h0);
        rd_a_sel = 3'd0; rd_a_wide = 0; rd_b_sel = 3'd2; rd_b_wide = 1; #1;
        check("R11", rd_a_data, 16'h005E);
        check("R11", rd_b_data, 16'h77EF);

        // R1 reset clears both banks and returns to main view
        do_reset();
        check("R1", af_rdata, 16'h0);
        read_a(3'd2, 1'b1, v); check("R1", v, 16'h0);
        read_a(3'd3, 1'b1, v); check("R1", v, 16'h0);
        read_a(3'd5, 1'b1, v); check("R1", v, 16'h0);
        cyc(0, 0, 3'd0, 16'h0, 1, 1, 0, 8'h0, 0, 16'h0);
        check("R1", af_rdata, 16'h0);
        read_a(3'd2, 1'b1, v); check("R1", v, 16'h0);
        do_reset();

        // random sequence against the reference model
        for (int b = 0; b < 2; b++) begin
            m_af[b] = 0; m_bc[b] = 0; m_de[b] = 0; m_hl[b] = 0;
        end
        m_ix = 0; m_iy = 0; m_sp = 0; s_af = 0; s_g = 0;
        for (int n = 0; n < 500; n++) begin
            int k;
            logic [2:0] s;
            logic [15:0] d;
            logic xa, xg, w;
            k = int'($urandom % 6);
            s = 3'($urandom);
            d = 16'($urandom);
            xa = ($urandom % 4) == 0;
            xg = ($urandom % 4) == 0;
            case (k)
                0: begin
                    cyc(1, 0, s, d, xa, xg, 0, 8'h0, 0, 16'h0);
                    case (s)
                        3'd0: m_bc[s_g][15:8] = d[7:0];
                        3'd1: m_bc[s_g][7:0]  = d[7:0];
                        3'd2: m_de[s_g][15:8] = d[7:0];
                        3'd3: m_de[s_g][7:0]  = d[7:0];
                        3'd4: m_hl[s_g][15:8] = d[7:0];
                        3'd5: m_hl[s_g][7:0]  = d[7:0];
                        3'd6: m_af[s_af][15:8] = d[7:0];
                        default: ;
                    endcase
                end
                1: begin
                    cyc(1, 1, s, d, xa, xg, 0, 8'h0, 0, 16'h0);
                    case (s)
                        3'd0: m_bc[s_g] = d;
                        3'd1: m_de[s_g] = d;
                        3'd2: m_hl[s_g] = d;
                        3'd3: m_ix = d;
                        3'd4: m_iy = d;
                        3'd5: m_sp = d;
                        default: ;
                    endcase
                end
                2: begin cyc(0, 0, 3'd0, 16'h0, 1, 0, 0, 8'h0, 0, 16'h0); xa = 1; xg = 0; end
                3: begin cyc(0, 0, 3'd0, 16'h0, 0, 1, 0, 8'h0, 0, 16'h0); xa = 0; xg = 1; end
                4: begin
                    cyc(0, 0, 3'd0, 16'h0, xa, xg, 0, 8'h0, 1, d);
                    m_af[s_af] = d;
                end
                default: begin
                    cyc(0, 0, 3'd0, 16'h0, xa, xg, 1, d[7:0], 0, 16'h0);
                    m_af[s_af][7:0] = (m_af[s_af][7:0] & 8'h3A) | (d[7:0] & 8'hC5);
                end
            endcase
            if (xa) s_af = ~s_af;
            if (xg) s_g = ~s_g;
            w = $urandom % 2;
            s = 3'($urandom);
            rd_b_sel = s; rd_b_wide = w; #1;
            check(w ? "R3" : "R2", rd_b_data, m_rd(s, w));
            check("R8", af_rdata, m_af[s_af]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule